// File: doc/BRIEF.md
# Standby and Reset-Vector Controller

This block sits beside a small processor core and decides two things: where the core starts fetching after a reset is released, and whether the core clock runs. While reset is held, the block records the reset cause and the interrupt level that the core reported. When reset is released, it issues the program-memory word address that holds the start vector, with a one-cycle strobe. A break-instruction reset normally uses a separate vector. If the core was already at an elevated interrupt level when the break ran, the block falls back to the ordinary vector instead.

The core stops itself by writing 1 to a halt-control bit. The free-running system clock keeps feeding peripherals, but a latch-based gate suppresses the core clock. A watchdog request, or any interrupt request whose enable line is set, clears the halt bit on the next falling edge of the system clock. The core clock then resumes with the next full pulse. The core can run up to two instructions before its interrupt entry, so software places two no-ops after the halt write. Every gating change happens while the system clock is low, so the core clock never carries a shortened pulse.

Top module: `stby_vec_top`

## Requirements
- R1: Reset-cause codes 0 (power-on), 1 (low-speed oscillator stop), 2 (watchdog overflow) and 3 (external pin), and the unassigned codes 5 to 7, give vecAddr = BASE_VEC (default 0x0002) at release.
- R2: Cause code 4 (break instruction) with intLevel below BRK_LVL_LIMIT (default 2) gives vecAddr = BRK_VEC (default 0x0004).
- R3: Cause code 4 with intLevel at or above BRK_LVL_LIMIT gives vecAddr = BASE_VEC.
- R4: rstCause and intLevel are taken from the last rising edge at which sysRst is high. vecValid is high for exactly the one cycle after the first rising edge with sysRst low. vecAddr keeps its value until the next release.
- R5: A rising edge with haltWrEn = 1 and haltWrData = 1 sets haltStat. From the next rising edge, cpuClk delivers no pulse while haltStat is 1.
- R6: While halted, wdtIrq = 1 or any irqReq[i] with irqEn[i] = 1 clears haltStat at the next falling edge of sysClk. A request whose enable bit is 0 leaves haltStat at 1 and cpuClk stopped.
- R7: After a wake-up, cpuClk delivers a pulse at the rising edge that follows the clearing falling edge. Every cpuClk pulse starts and ends together with a sysClk high phase.
- R8: If an enabled request is already present when the halt bit is written to 1, haltStat clears at the falling edge of the same cycle, and cpuClk loses no pulse.
- R9: A rising edge with sysRst high clears haltStat and vecValid.
- R10: Requests arriving while the core runs have no effect: haltStat stays 0 and cpuClk keeps pulsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Free-running system clock |
| sysRst | input | 1 | Synchronous reset, active high |
| rstCause | input | 3 | Reset cause code, valid while sysRst is high |
| intLevel | input | LVL_W | Core interrupt level at the time of the reset |
| haltWrEn | input | 1 | Write strobe for the halt-control bit |
| haltWrData | input | 1 | Value written to the halt-control bit |
| wdtIrq | input | 1 | Watchdog interrupt request |
| irqReq | input | NUM_IRQ | Maskable interrupt requests |
| irqEn | input | NUM_IRQ | Enable bit for each maskable request |
| cpuClk | output | 1 | Gated core clock |
| haltStat | output | 1 | Current halt bit |
| vecAddr | output | ADDR_W | Program word address of the start vector |
| vecValid | output | 1 | One-cycle strobe for vecAddr |

## Verification
The bench builds the block with four maskable request lines and a two-bit interrupt level, keeping the threshold at 2. This makes every level value reachable, and covers both levels on each side of the threshold as well as the threshold itself. With a narrower request vector, the bench can drive all lines high with no enables set, to show that masked requests are ignored, and then enable a single line to wake the core. The bench counts the cpuClk pulses seen in each system-clock cycle, so a lost, extra or early pulse around halt entry, wake-up or the pending-request case shows up in the cycle where it happens.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [2:0] {
    CAUSE_POWERON = 3'd0,
    CAUSE_OSCSTOP = 3'd1,
    CAUSE_WDOG    = 3'd2,
    CAUSE_PIN     = 3'd3,
    CAUSE_BREAK   = 3'd4
  } rstCause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;      // sample cause and level (reset held)
    logic issue;        // publish vector (first cycle after release)
    logic haltLoad;     // halt bit written by software
    logic haltLoadVal;  // value written
    logic haltDrop;     // wake seen on falling edge, retire halt bit
  } stbyStrobe_t;

endpackage

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int NUM_IRQ = 7
) (
  input  logic               sysClk,
  input  logic               sysRst,
  input  logic               haltWrEn,
  input  logic               haltWrData,
  input  logic               wdtIrq,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqEn,
  input  logic               haltBit,
  output logic               wakeSeen,
  output stbyStrobe_t        strobe
);

  logic               rstPending;
  logic [NUM_IRQ-1:0] maskedReq;
  logic               wakeAny;

  // per-line masking of requests
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mask
    assign maskedReq[i] = irqReq[i] & irqEn[i];
  end

  assign wakeAny = wdtIrq | (|maskedReq);

  // remembers that a reset has been held and not yet announced
  always_ff @(posedge sysClk) begin
    if (sysRst) begin
      rstPending <= 1'b1;
    end else if (rstPending) begin
      rstPending <= 1'b0;
    end
  end

  // wake detection on the falling edge of the system clock
  always_ff @(negedge sysClk) begin
    wakeSeen <= !sysRst && haltBit && wakeAny;
  end

  always_comb begin
    strobe.capture     = sysRst;
    strobe.issue       = !sysRst && rstPending;
    strobe.haltLoad    = !sysRst && haltWrEn;
    strobe.haltLoadVal = haltWrData;
    strobe.haltDrop    = !sysRst && wakeSeen;
  end

endmodule

// File: rtl/stby_datapath.sv
module stby_datapath
  import stby_pkg::*;
#(
  parameter int          ADDR_W        = 16,
  parameter int          LVL_W         = 2,
  parameter int unsigned BASE_VEC      = 2,
  parameter int unsigned BRK_VEC       = 4,
  parameter int unsigned BRK_LVL_LIMIT = 2
) (
  input  logic              sysClk,
  input  logic              sysRst,
  input  stbyStrobe_t       strobe,
  input  logic [2:0]        rstCause,
  input  logic [LVL_W-1:0]  intLevel,
  input  logic              wakeSeen,
  output logic              haltBit,
  output logic              haltStat,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              vecValid
);

  localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(BASE_VEC);
  localparam logic [ADDR_W-1:0] BRK_ADDR  = ADDR_W'(BRK_VEC);
  localparam logic [LVL_W:0]    LVL_LIM   = (LVL_W+1)'(BRK_LVL_LIMIT);

  rstCause_e         causeQ;
  logic [LVL_W-1:0]  levelQ;
  logic              takeBrk;
  logic [ADDR_W-1:0] nextAddr;

  // cause and level recorded every reset cycle, last one kept
  always_ff @(posedge sysClk) begin
    if (strobe.capture) begin
      causeQ <= rstCause_e'(rstCause);
      levelQ <= intLevel;
    end
  end

  assign takeBrk  = (causeQ == CAUSE_BREAK) && ({1'b0, levelQ} < LVL_LIM);
  assign nextAddr = takeBrk ? BRK_ADDR : BASE_ADDR;

  always_ff @(posedge sysClk) begin
    if (sysRst) begin
      vecValid <= 1'b0;
    end else begin
      vecValid <= strobe.issue;
    end
  end

  always_ff @(posedge sysClk) begin
    if (strobe.issue) begin
      vecAddr <= nextAddr;
    end
  end

  // halt bit: software write wins over a retiring wake
  always_ff @(posedge sysClk) begin
    if (sysRst) begin
      haltBit <= 1'b0;
    end else if (strobe.haltLoad) begin
      haltBit <= strobe.haltLoadVal;
    end else if (strobe.haltDrop) begin
      haltBit <= 1'b0;
    end
  end

  // visible bit falls on the falling edge that saw the wake
  assign haltStat = haltBit & ~wakeSeen;

endmodule

// File: rtl/stby_clk_gate.sv
module stby_clk_gate (
  input  logic sysClk,
  input  logic runEn,
  output logic cpuClk
);

  logic enLat;

  // enable may change only while the clock is low
  always_latch begin
    if (!sysClk) begin
      enLat = runEn;
    end
  end

  assign cpuClk = sysClk & enLat;

endmodule

// File: rtl/stby_vec_top.sv
module stby_vec_top
  import stby_pkg::*;
#(
  parameter int          ADDR_W        = 16,
  parameter int          LVL_W         = 2,
  parameter int          NUM_IRQ       = 7,
  parameter int unsigned BASE_VEC      = 2,
  parameter int unsigned BRK_VEC       = 4,
  parameter int unsigned BRK_LVL_LIMIT = 2
) (
  input  logic               sysClk,
  input  logic               sysRst,
  input  logic [2:0]         rstCause,
  input  logic [LVL_W-1:0]   intLevel,
  input  logic               haltWrEn,
  input  logic               haltWrData,
  input  logic               wdtIrq,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqEn,
  output logic               cpuClk,
  output logic               haltStat,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic               vecValid
);

  stbyStrobe_t strobe;
  logic        haltBit;
  logic        wakeSeen;

  stby_ctrl #(.NUM_IRQ(NUM_IRQ)) ctrl_i (
    .sysClk     (sysClk),
    .sysRst     (sysRst),
    .haltWrEn   (haltWrEn),
    .haltWrData (haltWrData),
    .wdtIrq     (wdtIrq),
    .irqReq     (irqReq),
    .irqEn      (irqEn),
    .haltBit    (haltBit),
    .wakeSeen   (wakeSeen),
    .strobe     (strobe)
  );

  stby_datapath #(
    .ADDR_W        (ADDR_W),
    .LVL_W         (LVL_W),
    .BASE_VEC      (BASE_VEC),
    .BRK_VEC       (BRK_VEC),
    .BRK_LVL_LIMIT (BRK_LVL_LIMIT)
  ) dp_i (
    .sysClk   (sysClk),
    .sysRst   (sysRst),
    .strobe   (strobe),
    .rstCause (rstCause),
    .intLevel (intLevel),
    .wakeSeen (wakeSeen),
    .haltBit  (haltBit),
    .haltStat (haltStat),
    .vecAddr  (vecAddr),
    .vecValid (vecValid)
  );

  stby_clk_gate gate_i (
    .sysClk (sysClk),
    .runEn  (!haltStat),
    .cpuClk (cpuClk)
  );

endmodule

// File: rtl/stby_vec_checker.sv
module stby_vec_checker #(
  parameter int          ADDR_W        = 16,
  parameter int          LVL_W         = 2,
  parameter int          NUM_IRQ       = 7,
  parameter int unsigned BASE_VEC      = 2,
  parameter int unsigned BRK_VEC       = 4,
  parameter int unsigned BRK_LVL_LIMIT = 2
) (
  input logic               sysClk,
  input logic               sysRst,
  input logic [2:0]         rstCause,
  input logic [LVL_W-1:0]   intLevel,
  input logic               haltWrEn,
  input logic               haltWrData,
  input logic               wdtIrq,
  input logic [NUM_IRQ-1:0] irqReq,
  input logic [NUM_IRQ-1:0] irqEn,
  input logic               cpuClk,
  input logic               haltStat,
  input logic [ADDR_W-1:0]  vecAddr,
  input logic               vecValid
);

  logic wakeAny;
  logic brkSel;

  assign wakeAny = wdtIrq | (|(irqReq & irqEn));
  assign brkSel  = (rstCause == 3'd4) && (32'(intLevel) < BRK_LVL_LIMIT);

  // R1 R2 R3: address matches the cause and level of the last reset cycle
  a_r2_vector_select: assert property (@(posedge sysClk) disable iff (sysRst)
    vecValid |-> (vecAddr == ($past(brkSel, 2) ? ADDR_W'(BRK_VEC) : ADDR_W'(BASE_VEC))));

  a_r4_strobe_single: assert property (@(posedge sysClk) disable iff (sysRst)
    vecValid |=> !vecValid);

  a_r4_strobe_after_release: assert property (@(posedge sysClk) disable iff (sysRst)
    ($past(sysRst) && !sysRst) |=> vecValid);

  // R5 and R8: halt set unless a wake was present at the following falling edge
  a_r5_halt_entry: assert property (@(posedge sysClk) disable iff (sysRst)
    (haltWrEn && haltWrData) |=> (haltStat == !wakeAny));

  a_r6_wake_or_hold: assert property (@(posedge sysClk) disable iff (sysRst)
    (haltStat && !haltWrEn) |=> (haltStat != wakeAny));

  a_r10_run_stays: assert property (@(posedge sysClk) disable iff (sysRst)
    (!haltStat && !haltWrEn) |=> !haltStat);

  a_r9_reset_clears: assert property (@(posedge sysClk)
    $past(sysRst) |-> (!haltStat && !vecValid));

  always @(posedge cpuClk) begin
    if (!sysRst) begin
      a_r7_clean_rise: assert (sysClk);
    end
  end

  always @(negedge cpuClk) begin
    if (!sysRst) begin
      a_r7_clean_fall: assert (!sysClk);
    end
  end

endmodule

bind stby_vec_top stby_vec_checker #(
  .ADDR_W        (ADDR_W),
  .LVL_W         (LVL_W),
  .NUM_IRQ       (NUM_IRQ),
  .BASE_VEC      (BASE_VEC),
  .BRK_VEC       (BRK_VEC),
  .BRK_LVL_LIMIT (BRK_LVL_LIMIT)
) chk_i (
  .sysClk     (sysClk),
  .sysRst     (sysRst),
  .rstCause   (rstCause),
  .intLevel   (intLevel),
  .haltWrEn   (haltWrEn),
  .haltWrData (haltWrData),
  .wdtIrq     (wdtIrq),
  .irqReq     (irqReq),
  .irqEn      (irqEn),
  .cpuClk     (cpuClk),
  .haltStat   (haltStat),
  .vecAddr    (vecAddr),
  .vecValid   (vecValid)
);

// File: tb/stby_vec_top_tb_top.sv
module stby_vec_top_tb_top;

  localparam int ADDR_W  = 16;
  localparam int LVL_W   = 2;
  localparam int NUM_IRQ = 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [2:0]         cause = 3'd0;
  logic [LVL_W-1:0]   lvl = '0;
  logic               wrEn = 1'b0;
  logic               wrData = 1'b0;
  logic               wdt = 1'b0;
  logic [NUM_IRQ-1:0] req = '0;
  logic [NUM_IRQ-1:0] ena = '0;
  logic               cpuClk;
  logic               haltStat;
  logic [ADDR_W-1:0]  vecAddr;
  logic               vecValid;

  always #5 clk = ~clk;  // 100 MHz

  stby_vec_top #(.ADDR_W(ADDR_W), .LVL_W(LVL_W), .NUM_IRQ(NUM_IRQ)) dut_i (
    .sysClk(clk), .sysRst(rst), .rstCause(cause), .intLevel(lvl),
    .haltWrEn(wrEn), .haltWrData(wrData), .wdtIrq(wdt),
    .irqReq(req), .irqEn(ena), .cpuClk(cpuClk), .haltStat(haltStat),
    .vecAddr(vecAddr), .vecValid(vecValid)
  );

  int nCheck = 0;
  int nFail  = 0;
  bit done   = 0;
  int pulseCnt = 0;

  always @(posedge cpuClk) pulseCnt++;

  // behavioural reference state
  bit mHalt = 0, mEn = 1, mEnKnown = 0, mNegKnown = 0;
  bit mInRst = 0, mValid = 0, mAddrKnown = 0;
  int mCause = 0, mLvl = 0, mAddr = 0;

  function automatic int expVec(int c, int l);
    return (c == 4 && l < 2) ? 4 : 2;  // R2 / R3 / R1
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    nCheck++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelPos();
    if (rst) begin
      mHalt = 0; mCause = cause; mLvl = lvl; mInRst = 1; mValid = 0;
    end else begin
      mValid = 0;
      if (mInRst) begin
        mValid = 1; mAddr = expVec(mCause, mLvl); mAddrKnown = 1; mInRst = 0;
      end
      if (wrEn) mHalt = wrData;
    end
  endtask

  task automatic modelNeg();
    if (!rst && mHalt && (wdt || ((req & ena) != '0))) mHalt = 0;
    mEn = !mHalt; mEnKnown = 1; mNegKnown = 1;
  endtask

  // caller sets inputs at posedge+2; one full cycle follows
  task automatic step(string tag);
    #2;
    if (mNegKnown) check(tag, "haltStat after rise", int'(haltStat), int'(mHalt));
    check(tag, "vecValid", int'(vecValid), int'(mValid));
    if (mAddrKnown) check(tag, "vecAddr", int'(vecAddr), mAddr);
    if (mEnKnown) check(tag, "cpuClk pulses", pulseCnt, mEn ? 1 : 0);
    pulseCnt = 0;
    @(negedge clk);
    modelNeg();
    #2;
    check(tag, "haltStat after fall", int'(haltStat), int'(mHalt));
    @(posedge clk);
    modelPos();
    #2;
  endtask

  task automatic idle(int n, string tag);
    wrEn = 0; wrData = 0;
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic doReset(int c, int l, string tag);
    rst = 1; cause = 3'(c); lvl = LVL_W'(l);
    step(tag); step(tag);
    rst = 0;
    idle(3, tag);
  endtask

  task automatic writeHalt(string tag);
    wrEn = 1; wrData = 1;
    step(tag);
    wrEn = 0; wrData = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nCheck++; nFail++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    @(posedge clk);
    modelPos();
    #2;
    idle(3, "R9");

    // vector selection, every cause code
    doReset(0, 3, "R1");
    doReset(1, 0, "R1");
    doReset(2, 1, "R1");
    doReset(3, 2, "R1");
    doReset(5, 0, "R1");
    doReset(7, 1, "R1");
    doReset(4, 0, "R2");
    doReset(4, 1, "R2");
    doReset(4, 2, "R3");
    doReset(4, 3, "R3");

    // R4: last reset cycle decides
    rst = 1; cause = 3'd4; lvl = 0; step("R4");
    cause = 3'd0; step("R4");
    rst = 0; cause = 3'd4; idle(4, "R4");

    // R10: requests while running
    wdt = 1; req = '1; ena = '1; idle(3, "R10");
    wdt = 0; req = '0; ena = '0; idle(1, "R10");

    // R5 / R6: halt, masked requests ignored, enabled one wakes
    writeHalt("R5");
    req = '1; ena = '0; idle(5, "R6");
    ena = 4'b0100; idle(1, "R6");
    req = '0; ena = '0; idle(2, "R7");  // two instruction slots

    // R6: watchdog wake
    writeHalt("R5");
    idle(3, "R6");
    wdt = 1; idle(1, "R6");
    wdt = 0; idle(2, "R7");

    // R8: request already pending at halt write
    req = 4'b0001; ena = 4'b0001;
    writeHalt("R8");
    idle(2, "R8");
    req = '0; ena = '0; idle(2, "R8");

    // R9: reset while halted
    writeHalt("R5");
    idle(2, "R9");
    rst = 1; cause = 3'd3; lvl = 0; step("R9"); step("R9");
    rst = 0; idle(4, "R9");

    finishRun();
  end

endmodule